// File: doc/BRIEF.md
# Packed/Scalar Single-Precision Compare and Min-Max Unit

This datapath takes two 128-bit operands, A and B. Each operand holds four IEEE single-precision values in 32-bit lanes, with lane 0 in bits 31:0. For each lane pair it computes one of three things: the larger value, the smaller value, or a compare mask. A compare mask is a lane of all ones when the chosen predicate holds and all zeros when it does not. The predicate is a 3-bit immediate. It selects one of eight relations, including ordered and unordered tests.

A mode input selects packed or scalar operation.
- In packed mode all four lanes are computed in parallel.
- In scalar mode only lane 0 is computed, and lanes 1 to 3 of the result are copied unchanged from operand A.

The ordering follows single-precision rules. Positive and negative zero are equal. Any pair that contains a NaN is unordered. Maximum and minimum return the B operand when either input is NaN or when both inputs are zeros of any sign.

The result is registered and appears one clock after a valid input, together with a valid flag. The block raises no flags and has no exception state.

Top module: `fp_lane_cmp_unit`

## Requirements
- R1: In packed mode (scalar_mode=0), each lane i of the result (bits 32i+31:32i) depends only on lane i of A and lane i of B, for all four lanes.
- R2: In scalar mode (scalar_mode=1), lane 0 of the result is computed, and lanes 1 to 3 equal lanes 1 to 3 of A.
- R3: op_sel=0 returns the numerically greater value of the pair, and op_sel=1 returns the numerically lesser value. Negative values order below positive ones, and infinities order at the extremes.
- R4: op_sel=2 and op_sel=3 both perform a compare. The result lane is 32'hFFFFFFFF when the predicate holds and 32'h00000000 when it does not.
- R5: The predicate encoding is: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. Each relation is A relative to B.
- R6: A value is NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A pair with a NaN is unordered. Predicates 3, 4, 5 and 6 are true for an unordered pair, and predicates 0, 1, 2 and 7 are false.
- R7: For max and min, if either input is NaN, or if both inputs are zeros of either sign, the result lane is the B value bit for bit.
- R8: +0 (32'h00000000) and -0 (32'h80000000) compare as equal and as not less than each other.
- R9: out_valid equals in_valid delayed by one clock. out_data updates only in the clock after a valid input and holds otherwise.
- R10: While rst_n is low, out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 0 max, 1 min, 2 or 3 compare |
| pred | input | 3 | Compare predicate immediate |
| scalar_mode | input | 1 | 1 computes lane 0 only, 0 computes all lanes |
| src_a | input | 128 | First operand, four single-precision lanes |
| src_b | input | 128 | Second operand, four single-precision lanes |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Registered result |

## Verification
The bench drives a set of mixed-sign and infinity pairs. A design that compared raw bit patterns as integers would get the max and min of negative values backwards. Signed-zero pairs are also included: a design that treated -0 as less than +0 would fail the equal and not-equal masks, and one that did not return B for a pair of zeros would return the wrong sign. NaN lanes are run under all eight predicates and both min and max. A design that let a NaN fall through its magnitude compare would set the ordered, less-than or equal masks wrongly, or would return A. Scalar-mode vectors load lanes 1 to 3 of A with values that differ from any computed result, including a NaN. A design that computed or cleared those lanes would show a wrong upper lane.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [1:0] {
        OP_MAX     = 2'd0,
        OP_MIN     = 2'd1,
        OP_CMP     = 2'd2,
        OP_CMP_ALT = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PR_EQ   = 3'd0,
        PR_LT   = 3'd1,
        PR_LE   = 3'd2,
        PR_UNO  = 3'd3,
        PR_NEQ  = 3'd4,
        PR_NLT  = 3'd5,
        PR_NLE  = 3'd6,
        PR_ORD  = 3'd7
    } pred_e;

endpackage

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
    parameter int ELEM_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic              unord,
    output logic              lt,
    output logic              eq,
    output logic              both_zero
);
    localparam int MAN_W = ELEM_W - 1 - EXP_W;
    localparam int SGN   = ELEM_W - 1;

    logic a_nan, b_nan;
    logic a_sgn, b_sgn;
    logic [ELEM_W-2:0] a_mag, b_mag;
    logic raw_lt, raw_eq;

    always_comb begin
        a_sgn = a[SGN];
        b_sgn = b[SGN];
        a_mag = a[ELEM_W-2:0];
        b_mag = b[ELEM_W-2:0];
        a_nan = (&a[ELEM_W-2:MAN_W]) && (|a[MAN_W-1:0]);
        b_nan = (&b[ELEM_W-2:MAN_W]) && (|b[MAN_W-1:0]);
        both_zero = (a_mag == '0) && (b_mag == '0);
        unord = a_nan || b_nan;

        if (both_zero) begin
            raw_lt = 1'b0;
            raw_eq = 1'b1;
        end else if (a_sgn != b_sgn) begin
            raw_lt = a_sgn;
            raw_eq = 1'b0;
        end else begin
            raw_eq = (a_mag == b_mag);
            raw_lt = a_sgn ? (a_mag > b_mag) : (a_mag < b_mag);
        end

        lt = raw_lt && !unord;
        eq = raw_eq && !unord;
    end

    // R6: an unordered pair is neither less-than nor equal
    always_comb begin
        assert_unord_excl_R6: assert (!(unord && (lt || eq)));
        assert_lt_eq_excl_R5: assert (!(lt && eq));
    end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    input  op_e               op,
    input  pred_e             pred,
    output logic [ELEM_W-1:0] res
);
    logic unord, lt, eq, both_zero;
    logic hit;
    logic pick_b;

    fpcmp_order #(.ELEM_W(ELEM_W), .EXP_W(EXP_W)) u_order (
        .a         (a),
        .b         (b),
        .unord     (unord),
        .lt        (lt),
        .eq        (eq),
        .both_zero (both_zero)
    );

    always_comb begin
        unique case (pred)
            PR_EQ:  hit = eq;
            PR_LT:  hit = lt;
            PR_LE:  hit = lt || eq;
            PR_UNO: hit = unord;
            PR_NEQ: hit = !eq;
            PR_NLT: hit = !lt;
            PR_NLE: hit = !(lt || eq);
            PR_ORD: hit = !unord;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        pick_b = 1'b1;
        res    = b;
        unique case (op)
            OP_MAX: begin
                pick_b = unord || both_zero || !(!lt && !eq);
                res    = pick_b ? b : a;
            end
            OP_MIN: begin
                pick_b = unord || both_zero || !lt;
                res    = pick_b ? b : a;
            end
            OP_CMP, OP_CMP_ALT: begin
                res = {ELEM_W{hit}};
            end
            default: res = b;
        endcase
    end

    // R7/R3: max and min always return one of the two inputs
    always_comb begin
        if (op == OP_MAX || op == OP_MIN)
            assert_minmax_member_R7: assert (res == a || res == b);
    end

endmodule

// File: rtl/fp_lane_cmp_unit.sv
module fp_lane_cmp_unit
    import fpcmp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              op_sel,
    input  logic [2:0]              pred,
    input  logic                    scalar_mode,
    input  logic [LANES*ELEM_W-1:0] src_a,
    input  logic [LANES*ELEM_W-1:0] src_b,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_data
);
    localparam int DW = LANES * ELEM_W;

    op_e   op_q;
    pred_e pred_q;
    logic [DW-1:0] lane_res;
    logic [DW-1:0] next_data;

    assign op_q   = op_e'(op_sel);
    assign pred_q = pred_e'(pred);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpcmp_lane #(.ELEM_W(ELEM_W), .EXP_W(EXP_W)) u_lane (
            .a    (src_a[i*ELEM_W +: ELEM_W]),
            .b    (src_b[i*ELEM_W +: ELEM_W]),
            .op   (op_q),
            .pred (pred_q),
            .res  (lane_res[i*ELEM_W +: ELEM_W])
        );

        if (i == 0) begin : g_low
            assign next_data[ELEM_W-1:0] = lane_res[ELEM_W-1:0];
        end else begin : g_high
            assign next_data[i*ELEM_W +: ELEM_W] = scalar_mode ?
                src_a[i*ELEM_W +: ELEM_W] : lane_res[i*ELEM_W +: ELEM_W];
        end

        // R4: a compare produces an all-ones or all-zeros lane
        assert_cmp_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_sel[1] && (!scalar_mode || i == 0)) |=>
            (out_data[i*ELEM_W +: ELEM_W] == '0 || out_data[i*ELEM_W +: ELEM_W] == '1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_data;
        end
    end

    // R9: one-cycle valid latency and hold when idle
    assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(out_data));

    // R2: scalar mode copies the upper lanes of A
    assert_scalar_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar_mode) |=> out_data[DW-1:ELEM_W] == $past(src_a[DW-1:ELEM_W]));

endmodule

// File: tb/fp_lane_cmp_unit_test.sv
module fp_lane_cmp_unit_test;
    localparam int NV = 15;
    localparam int VW = 2 + 3 + 1 + 128 * 3;

    // {op, pred, scalar, A, B, expected}
    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        // R1 R3 max packed
        {2'd0, 3'd0, 1'b0, 128'h3F800000_BF800000_C0000000_7F800000,
                           128'h40000000_C0000000_BF800000_40400000,
                           128'h40000000_BF800000_BF800000_7F800000},
        // R1 R3 min packed
        {2'd1, 3'd0, 1'b0, 128'h3F800000_BF800000_C0000000_7F800000,
                           128'h40000000_C0000000_BF800000_40400000,
                           128'h3F800000_C0000000_C0000000_40400000},
        // R7 max NaN / zeros
        {2'd0, 3'd0, 1'b0, 128'h7FC00000_3F800000_00000000_80000000,
                           128'h3F800000_7FC00000_80000000_00000000,
                           128'h3F800000_7FC00000_80000000_00000000},
        // R7 min NaN / zeros
        {2'd1, 3'd0, 1'b0, 128'h7FC00000_3F800000_00000000_80000000,
                           128'h3F800000_7FC00000_80000000_00000000,
                           128'h3F800000_7FC00000_80000000_00000000},
        // R5 R8 pred 0 equal
        {2'd2, 3'd0, 1'b0, 128'h00000000_3F800000_7FC00000_40000000,
                           128'h80000000_40000000_7FC00000_40000000,
                           128'hFFFFFFFF_00000000_00000000_FFFFFFFF},
        // R5 pred 1 less-than
        {2'd2, 3'd1, 1'b0, 128'hBF800000_3F800000_7FC00000_40000000,
                           128'h3F800000_3F800000_3F800000_3F800000,
                           128'hFFFFFFFF_00000000_00000000_00000000},
        // R5 pred 2 less-or-equal
        {2'd2, 3'd2, 1'b0, 128'hBF800000_3F800000_7FC00000_40000000,
                           128'h3F800000_3F800000_3F800000_3F800000,
                           128'hFFFFFFFF_FFFFFFFF_00000000_00000000},
        // R6 pred 3 unordered
        {2'd2, 3'd3, 1'b0, 128'h7FC00000_3F800000_FF800000_3F800000,
                           128'h3F800000_7FC00000_7F800000_3F800000,
                           128'hFFFFFFFF_FFFFFFFF_00000000_00000000},
        // R6 R8 pred 4 not-equal
        {2'd2, 3'd4, 1'b0, 128'h00000000_3F800000_7FC00000_40400000,
                           128'h80000000_3F800000_3F800000_40000000,
                           128'h00000000_00000000_FFFFFFFF_FFFFFFFF},
        // R6 pred 5 not-less-than
        {2'd2, 3'd5, 1'b0, 128'hBF800000_3F800000_7FC00000_40000000,
                           128'h3F800000_3F800000_3F800000_3F800000,
                           128'h00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF},
        // R6 pred 6 not-less-or-equal
        {2'd2, 3'd6, 1'b0, 128'hBF800000_3F800000_7FC00000_40000000,
                           128'h3F800000_3F800000_3F800000_3F800000,
                           128'h00000000_00000000_FFFFFFFF_FFFFFFFF},
        // R6 pred 7 ordered
        {2'd2, 3'd7, 1'b0, 128'h7FC00000_3F800000_FF800000_3F800000,
                           128'h3F800000_7FC00000_7F800000_3F800000,
                           128'h00000000_00000000_FFFFFFFF_FFFFFFFF},
        // R2 scalar max
        {2'd0, 3'd0, 1'b1, 128'h40400000_7FC00000_BF800000_3F800000,
                           128'h00000000_00000000_00000000_40000000,
                           128'h40400000_7FC00000_BF800000_40000000},
        // R2 scalar compare less-than
        {2'd2, 3'd1, 1'b1, 128'h3F800000_40000000_C0000000_BF800000,
                           128'h40400000_40400000_40400000_3F800000,
                           128'h3F800000_40000000_C0000000_FFFFFFFF},
        // R4 op 3 is also compare
        {2'd3, 3'd0, 1'b0, 128'h3F800000_3F800000_3F800000_3F800000,
                           128'h3F800000_3F800000_3F800000_3F800000,
                           128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic [2:0]   pred;
    logic         scalar_mode;
    logic [127:0] src_a, src_b;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fp_lane_cmp_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .pred(pred), .scalar_mode(scalar_mode), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [2:0] p, input logic s,
                         input logic [127:0] a, input logic [127:0] b);
        op_sel = o; pred = p; scalar_mode = s; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; pred = '0;
        scalar_mode = 1'b0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {127'd0, out_valid}, 128'd0);
        chk("R10 reset data", out_data, 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][VW-1 -: 2], VEC[i][VW-3 -: 3], VEC[i][VW-6],
                  VEC[i][383:256], VEC[i][255:128]);
            chk($sformatf("R9 valid vec%0d", i), {127'd0, out_valid}, 128'd1);
            chk($sformatf("R1-vector %0d (R3 R4 R5 R6 R7 R8 R2)", i), out_data, VEC[i][127:0]);
        end

        // R9: idle cycle drops valid and holds data, even with changing inputs
        in_valid = 1'b0; src_a = '1; src_b = '0; op_sel = 2'd0;
        @(negedge clk);
        chk("R9 idle valid", {127'd0, out_valid}, 128'd0);
        chk("R9 hold data", out_data, VEC[NV-1][127:0]);
        @(negedge clk);
        chk("R9 hold data 2", out_data, VEC[NV-1][127:0]);

        // R1: changing only lane 2 of A changes only lane 2 of the max
        drive(2'd0, 3'd0, 1'b0, 128'h3F800000_C0000000_3F800000_3F800000,
                                128'h40000000_40000000_40000000_40000000);
        chk("R1 lane isolate a", out_data, 128'h40000000_40000000_40000000_40000000);
        drive(2'd0, 3'd0, 1'b0, 128'h3F800000_40400000_3F800000_3F800000,
                                128'h40000000_40000000_40000000_40000000);
        chk("R1 lane isolate b", out_data, 128'h40000000_40400000_40000000_40000000);

        // R3: negative magnitudes and -inf
        drive(2'd1, 3'd0, 1'b0, 128'hFF800000_C0400000_BF800000_00000000,
                                128'hC0000000_C0000000_C0000000_BF800000);
        chk("R3 min negatives", out_data, 128'hFF800000_C0400000_C0000000_BF800000);

        // R10: reset mid-run clears the output
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset data", out_data, 128'd0);
        chk("R10 mid reset valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule